// File: doc/BRIEF.md
# Predicated Contiguous Vector Load/Store Unit

The block executes one predicated, contiguous vector memory operation at a time for a core whose vector length is a parameter. A 4-bit format code selects the register element width and the memory element width together. Some codes make a load widen narrow memory elements with sign extension, others with zero extension. The block forms the effective address from a base and either a signed immediate, scaled by the whole access size, or a scalar offset, scaled by the memory element size. It then makes a single request to a byte-addressed memory port. Write data and byte enables are packed contiguously, little-endian, starting at the effective address.

A caller pulses `start` with the operation fields while the unit is idle. A legal, aligned operation raises `busy` and holds `mem_req` until the memory answers with `mem_ack`. One cycle later the unit pulses `done`, and for a load the widened or narrowed vector appears on `vec_out`. An operation that is rejected pulses `undef` or `fault` in place of `done`, and it never touches memory.

Top module: `pvl_lsu`

## Requirements
- R1: The format code `dtype` selects (register bits / memory bits / extension): 0=8/8/zero, 1=16/8/zero, 2=32/8/zero, 3=64/8/zero, 4=64/32/sign, 5=16/16/zero, 6=32/16/zero, 7=64/16/zero, 8=64/16/sign, 9=32/16/sign, A=32/32/zero, B=64/32/zero, C=64/8/sign, D=32/8/sign, E=16/8/sign, F=64/64/zero. The element count is VLEN divided by the register element width.
- R2: A store with any sign-extending code (4, 8, 9, C, D, E) pulses `undef` one cycle after `start` and makes no memory request.
- R3: When `base_is_sp` and `align_chk_en` are both high and `base[3:0]` is nonzero, the operation pulses `fault` one cycle after `start` and makes no memory request. An illegal store code takes precedence, so that case gives `undef` only. Alignment is not checked in any other case.
- R4: In immediate form (`imm_form`=1), `mem_addr` = `base` + sign-extended `imm` × element count × memory element bytes.
- R5: In register form (`imm_form`=0), `mem_addr` = `base` + `offset` × memory element bytes.
- R6: `acc_bytes` = element count × memory element bytes. It is always a power of two. A load enables exactly byte lanes 0..`acc_bytes`-1 of `mem_be`.
- R7: On a load, memory element i is read from bytes i×m..i×m+m-1 of `mem_rdata` (m = memory element bytes, little-endian). It is written to register element i, sign- or zero-extended according to R1. Predicate bit i of `pred` governs element i.
- R8: On a load, an element whose predicate bit is 0 is written as zero in `vec_out`.
- R9: On a store, active element i writes the low m bytes of register element i at bytes i×m.. of the access. An inactive element has its byte enables cleared and its `mem_wdata` bytes at zero. Bytes beyond `acc_bytes` are never enabled.
- R10: `mem_req` stays high, with a stable address, until `mem_ack`. `done` pulses exactly one cycle after the acknowledged cycle. At most one of `done`, `fault` and `undef` is high. A `start` while `busy` is ignored, and a store leaves `vec_out` unchanged.
- R11: After reset, `busy`, `done`, `fault`, `undef` and `mem_req` are low and `vec_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| imm_form | input | 1 | 1 = base + scaled immediate, 0 = base + scaled offset |
| dtype | input | 4 | Register/memory element format code |
| base | input | AW | Base address |
| base_is_sp | input | 1 | Base register is the stack pointer |
| align_chk_en | input | 1 | Stack-pointer alignment checking enabled |
| imm | input | IMM_W | Signed immediate, in units of whole accesses |
| offset | input | AW | Scalar offset, in memory elements |
| pred | input | VLEN/8 | Governing predicate, bit i for element i |
| vec_in | input | VLEN | Register value for stores |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle alignment fault pulse |
| undef | output | 1 | One-cycle illegal store code pulse |
| vec_out | output | VLEN | Load result |
| acc_bytes | output | log2(VLEN/8)+1 | Access size in bytes of the current request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Effective byte address |
| mem_be | output | VLEN/8 | Byte enables, byte k at address mem_addr+k |
| mem_wdata | output | VLEN | Write data, byte k at address mem_addr+k |
| mem_ack | input | 1 | Memory accepted / returned data this cycle |
| mem_rdata | input | VLEN | Read data, byte k from address mem_addr+k |

## Verification
The illegal-store check and the stack-pointer alignment check are both decided in the cycle that accepts `start`, so both can apply to the same operation. The bench provokes this with a sign-extending store code on a misaligned stack-pointer base with checking enabled. It expects `undef` alone, no `fault`, no request and memory unchanged. A second overlap drives a new `start` while a load waits for its acknowledge. The bench then requires a single `done`, the first load's data and no write to memory.

// File: rtl/pvl_pkg.sv
package pvl_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } pvl_state_e;

  // log2 of register bytes, log2 of memory bytes, sign extension
  typedef struct packed {
    logic [1:0] rlog;
    logic [1:0] mlog;
    logic       sext;
  } pvl_fmt_t;

  function automatic pvl_fmt_t pvl_fmt(input logic [3:0] code);
    pvl_fmt_t f;
    f = '{rlog: 2'd0, mlog: 2'd0, sext: 1'b0};
    case (code)
      4'h0: f = '{rlog: 2'd0, mlog: 2'd0, sext: 1'b0};
      4'h1: f = '{rlog: 2'd1, mlog: 2'd0, sext: 1'b0};
      4'h2: f = '{rlog: 2'd2, mlog: 2'd0, sext: 1'b0};
      4'h3: f = '{rlog: 2'd3, mlog: 2'd0, sext: 1'b0};
      4'h4: f = '{rlog: 2'd3, mlog: 2'd2, sext: 1'b1};
      4'h5: f = '{rlog: 2'd1, mlog: 2'd1, sext: 1'b0};
      4'h6: f = '{rlog: 2'd2, mlog: 2'd1, sext: 1'b0};
      4'h7: f = '{rlog: 2'd3, mlog: 2'd1, sext: 1'b0};
      4'h8: f = '{rlog: 2'd3, mlog: 2'd1, sext: 1'b1};
      4'h9: f = '{rlog: 2'd2, mlog: 2'd1, sext: 1'b1};
      4'hA: f = '{rlog: 2'd2, mlog: 2'd2, sext: 1'b0};
      4'hB: f = '{rlog: 2'd3, mlog: 2'd2, sext: 1'b0};
      4'hC: f = '{rlog: 2'd3, mlog: 2'd0, sext: 1'b1};
      4'hD: f = '{rlog: 2'd2, mlog: 2'd0, sext: 1'b1};
      4'hE: f = '{rlog: 2'd1, mlog: 2'd0, sext: 1'b1};
      default: f = '{rlog: 2'd3, mlog: 2'd3, sext: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pvl_agen.sv
module pvl_agen
  import pvl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 4,
  parameter int LB    = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    offset,
  input  logic             imm_form,
  input  pvl_fmt_t         fmt,
  output logic [AW-1:0]    ea,
  output logic [LB:0]      acc_bytes
);

  logic [AW-1:0] imm_x;
  int            sh;

  always_comb begin
    // access size = 2^(LB - rlog + mlog) bytes
    sh        = LB - int'(fmt.rlog) + int'(fmt.mlog);
    acc_bytes = (LB+1)'(1) << sh;
    imm_x     = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
    if (imm_form) ea = base + (imm_x << sh);
    else          ea = base + (offset << fmt.mlog);
  end

endmodule

// File: rtl/pvl_load_lanes.sv
module pvl_load_lanes
  import pvl_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VB  = VLEN / 8,
  localparam int LB  = $clog2(VB)
) (
  input  logic [VLEN-1:0] rdata,
  input  logic [VB-1:0]   pred,
  input  pvl_fmt_t        fmt,
  output logic [VLEN-1:0] vec_o
);

  for (genvar p = 0; p < VB; p++) begin : g_rbyte
    localparam logic [LB-1:0] POS = LB'(p);
    logic [LB-1:0] elem, sub, src, sidx;
    logic          in_mem;
    logic [7:0]    lane_byte;

    always_comb begin
      elem   = POS >> fmt.rlog;
      sub    = POS & ((LB'(1) << fmt.rlog) - LB'(1));
      src    = (elem << fmt.mlog) + sub;
      sidx   = (elem << fmt.mlog) + ((LB'(1) << fmt.mlog) - LB'(1));
      in_mem = (sub >> fmt.mlog) == '0;
      if (!pred[elem])  lane_byte = '0;
      else if (in_mem)  lane_byte = rdata[{src, 3'b000} +: 8];
      else              lane_byte = {8{fmt.sext & rdata[{sidx, 3'b111}]}};
    end

    assign vec_o[p*8 +: 8] = lane_byte;
  end

endmodule

// File: rtl/pvl_store_lanes.sv
module pvl_store_lanes
  import pvl_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int VB  = VLEN / 8,
  localparam int LB  = $clog2(VB)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [VB-1:0]   pred,
  input  pvl_fmt_t        fmt,
  input  logic [LB:0]     acc_bytes,
  output logic [VLEN-1:0] wdata,
  output logic [VB-1:0]   wbe,
  output logic [VB-1:0]   rng
);

  for (genvar q = 0; q < VB; q++) begin : g_mbyte
    localparam logic [LB-1:0] POS = LB'(q);
    logic [LB-1:0] elem, sub, src;
    logic          in_rng, wr;

    always_comb begin
      elem   = POS >> fmt.mlog;
      sub    = POS & ((LB'(1) << fmt.mlog) - LB'(1));
      src    = (elem << fmt.rlog) + sub;
      in_rng = {1'b0, POS} < acc_bytes;
      wr     = in_rng & pred[elem];
    end

    assign rng[q]          = in_rng;
    assign wbe[q]          = wr;
    assign wdata[q*8 +: 8] = wr ? vec[{src, 3'b000} +: 8] : 8'h00;
  end

endmodule

// File: rtl/pvl_lsu.sv
module pvl_lsu
  import pvl_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int AW    = 32,
  parameter int IMM_W = 4,
  localparam int VB   = VLEN / 8,
  localparam int LB   = $clog2(VB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_store,
  input  logic             imm_form,
  input  logic [3:0]       dtype,
  input  logic [AW-1:0]    base,
  input  logic             base_is_sp,
  input  logic             align_chk_en,
  input  logic [IMM_W-1:0] imm,
  input  logic [AW-1:0]    offset,
  input  logic [VB-1:0]    pred,
  input  logic [VLEN-1:0]  vec_in,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             undef,
  output logic [VLEN-1:0]  vec_out,
  output logic [LB:0]      acc_bytes,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [VB-1:0]    mem_be,
  output logic [VLEN-1:0]  mem_wdata,
  input  logic             mem_ack,
  input  logic [VLEN-1:0]  mem_rdata
);

  pvl_state_e       state_q, state_n;
  logic             done_q, done_n, fault_q, fault_n, undef_q, undef_n;
  logic             op_store_q, op_immf_q;
  logic [3:0]       op_code_q;
  logic [AW-1:0]    op_base_q, op_off_q;
  logic [IMM_W-1:0] op_imm_q;
  logic [VB-1:0]    op_pred_q;
  logic [VLEN-1:0]  op_vec_q, vec_out_q;
  logic             latch_en, cap_en;
  logic             in_bad, misalign;
  pvl_fmt_t         fmt;
  logic [VLEN-1:0]  ld_vec, st_wdata;
  logic [VB-1:0]    st_be, st_rng;

  assign in_bad   = is_store & pvl_fmt(dtype).sext;
  assign misalign = base_is_sp & align_chk_en & (base[3:0] != 4'h0);
  assign fmt      = pvl_fmt(op_code_q);

  pvl_agen #(.AW(AW), .IMM_W(IMM_W), .LB(LB)) u_agen (
    .base(op_base_q), .imm(op_imm_q), .offset(op_off_q),
    .imm_form(op_immf_q), .fmt(fmt), .ea(mem_addr), .acc_bytes(acc_bytes)
  );

  pvl_load_lanes #(.VLEN(VLEN)) u_ld (
    .rdata(mem_rdata), .pred(op_pred_q), .fmt(fmt), .vec_o(ld_vec)
  );

  pvl_store_lanes #(.VLEN(VLEN)) u_st (
    .vec(op_vec_q), .pred(op_pred_q), .fmt(fmt), .acc_bytes(acc_bytes),
    .wdata(st_wdata), .wbe(st_be), .rng(st_rng)
  );

  // next-state
  always_comb begin
    state_n  = state_q;
    done_n   = 1'b0;
    fault_n  = 1'b0;
    undef_n  = 1'b0;
    latch_en = 1'b0;
    cap_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (in_bad)        undef_n = 1'b1;
          else if (misalign) fault_n = 1'b1;
          else begin
            latch_en = 1'b1;
            state_n  = ST_REQ;
          end
        end
      end
      default: begin
        if (mem_ack) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
          cap_en  = ~op_store_q;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      fault_q <= fault_n;
      undef_q <= undef_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_store_q <= 1'b0;
      op_immf_q  <= 1'b0;
      op_code_q  <= '0;
      op_base_q  <= '0;
      op_off_q   <= '0;
      op_imm_q   <= '0;
      op_pred_q  <= '0;
      op_vec_q   <= '0;
    end else if (latch_en) begin
      op_store_q <= is_store;
      op_immf_q  <= imm_form;
      op_code_q  <= dtype;
      op_base_q  <= base;
      op_off_q   <= offset;
      op_imm_q   <= imm;
      op_pred_q  <= pred;
      op_vec_q   <= vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_out_q <= '0;
    else if (cap_en) vec_out_q <= ld_vec;
  end

  assign busy      = (state_q == ST_REQ);
  assign done      = done_q;
  assign fault     = fault_q;
  assign undef     = undef_q;
  assign vec_out   = vec_out_q;
  assign mem_req   = busy;
  assign mem_we    = op_store_q;
  assign mem_be    = op_store_q ? st_be : st_rng;
  assign mem_wdata = op_store_q ? st_wdata : '0;

endmodule

// File: rtl/pvl_lsu_chk.sv
module pvl_lsu_chk #(
  parameter int VLEN  = 128,
  parameter int AW    = 32,
  localparam int VB   = VLEN / 8,
  localparam int LB   = $clog2(VB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            is_store,
  input logic [3:0]      dtype,
  input logic [AW-1:0]   base,
  input logic            base_is_sp,
  input logic            align_chk_en,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic            undef,
  input logic [LB:0]     acc_bytes,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [VB-1:0]   mem_be,
  input logic [VLEN-1:0] mem_wdata,
  input logic            mem_ack
);

  logic            sign_code;
  logic [VLEN-1:0] be_mask;

  assign sign_code = (dtype == 4'h4) || (dtype == 4'h8) || (dtype == 4'h9) ||
                     (dtype == 4'hC) || (dtype == 4'hD) || (dtype == 4'hE);

  always_comb begin
    for (int k = 0; k < VB; k++) be_mask[k*8 +: 8] = {8{mem_be[k]}};
  end

  // R2
  store_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && is_store && sign_code |=> undef && !mem_req);

  // R3
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && base_is_sp && align_chk_en && (base[3:0] != 4'h0) &&
    !(is_store && sign_code) |=> fault && !undef && !mem_req);

  // R6
  acc_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(acc_bytes) == 1);

  // R6
  load_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> $countones(mem_be) == int'(acc_bytes));

  // R9
  wdata_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_wdata & ~be_mask) == '0);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done && !busy);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, undef}));

endmodule

bind pvl_lsu pvl_lsu_chk #(.VLEN(VLEN), .AW(AW)) u_chk (.*);

// File: tb/pvl_lsu_tb.sv
`timescale 1ns/1ps
module pvl_lsu_tb;

  localparam int VLEN = 128;
  localparam int AW   = 32;
  localparam int VB   = VLEN / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start, is_store, imm_form, base_is_sp, align_chk_en;
  logic [3:0] dtype;
  logic [AW-1:0] base, offset;
  logic [3:0] imm;
  logic [VB-1:0] pred;
  logic [VLEN-1:0] vec_in;
  logic busy, done, fault, undef;
  logic [VLEN-1:0] vec_out;
  logic [4:0] acc_bytes;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [VB-1:0] mem_be;
  logic [VLEN-1:0] mem_wdata, mem_rdata;

  logic [7:0] bmem [0:255];
  logic [7:0] smem [0:255];

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  pvl_lsu #(.VLEN(VLEN), .AW(AW), .IMM_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .imm_form(imm_form), .dtype(dtype), .base(base), .base_is_sp(base_is_sp),
    .align_chk_en(align_chk_en), .imm(imm), .offset(offset), .pred(pred),
    .vec_in(vec_in), .busy(busy), .done(done), .fault(fault), .undef(undef),
    .vec_out(vec_out), .acc_bytes(acc_bytes), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledge after one wait cycle
  always @(negedge clk) mem_ack <= mem_req && !mem_ack;
  always_comb begin
    for (int k = 0; k < VB; k++) mem_rdata[k*8 +: 8] = bmem[mem_addr[7:0] + 8'(k)];
  end
  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we)
      for (int k = 0; k < VB; k++)
        if (mem_be[k]) bmem[mem_addr[7:0] + 8'(k)] <= mem_wdata[k*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fmt_of(input logic [3:0] c, output int rb, output int mb, output bit sg);
    case (c)
      4'h0: begin rb = 1; mb = 1; sg = 0; end
      4'h1: begin rb = 2; mb = 1; sg = 0; end
      4'h2: begin rb = 4; mb = 1; sg = 0; end
      4'h3: begin rb = 8; mb = 1; sg = 0; end
      4'h4: begin rb = 8; mb = 4; sg = 1; end
      4'h5: begin rb = 2; mb = 2; sg = 0; end
      4'h6: begin rb = 4; mb = 2; sg = 0; end
      4'h7: begin rb = 8; mb = 2; sg = 0; end
      4'h8: begin rb = 8; mb = 2; sg = 1; end
      4'h9: begin rb = 4; mb = 2; sg = 1; end
      4'hA: begin rb = 4; mb = 4; sg = 0; end
      4'hB: begin rb = 8; mb = 4; sg = 0; end
      4'hC: begin rb = 8; mb = 1; sg = 1; end
      4'hD: begin rb = 4; mb = 1; sg = 1; end
      4'hE: begin rb = 2; mb = 1; sg = 1; end
      default: begin rb = 8; mb = 8; sg = 0; end
    endcase
  endtask

  bit r_done, r_fault, r_undef, r_req;
  logic [AW-1:0] r_addr;
  logic [4:0] r_acc;

  task automatic run_op(input bit st, input bit f, input logic [3:0] c, input logic [AW-1:0] b,
                        input bit sp, input bit ce, input logic [3:0] im, input logic [AW-1:0] of,
                        input logic [VB-1:0] pr, input logic [VLEN-1:0] vi);
    @(negedge clk);
    start = 1; is_store = st; imm_form = f; dtype = c; base = b; base_is_sp = sp;
    align_chk_en = ce; imm = im; offset = of; pred = pr; vec_in = vi;
    @(negedge clk);
    start = 0;
    r_done = 0; r_fault = 0; r_undef = 0; r_req = 0; r_addr = '0; r_acc = '0;
    for (int n = 0; n < 20; n++) begin
      if (mem_req && !r_req) begin r_req = 1; r_addr = mem_addr; r_acc = acc_bytes; end
      if (done || fault || undef) begin
        r_done = done; r_fault = fault; r_undef = undef;
        break;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [AW-1:0] exp_ea(input bit f, input logic [AW-1:0] b, input logic [3:0] im,
                                           input logic [AW-1:0] of, input int sz, input int mb);
    int sim = $signed(im);
    if (f) return b + AW'(sim * sz);
    return b + of * AW'(mb);
  endfunction

  function automatic bit mem_same();
    for (int a = 0; a < 256; a++) if (bmem[a] !== smem[a]) return 0;
    return 1;
  endfunction

  task automatic load_case(input logic [3:0] c, input bit f, input logic [AW-1:0] b,
                           input logic [3:0] im, input logic [AW-1:0] of, input logic [VB-1:0] pr);
    int rb, mb, ec, sz;
    bit sg;
    logic [AW-1:0] ea;
    logic [VLEN-1:0] ev;
    fmt_of(c, rb, mb, sg);
    ec = VB / rb; sz = ec * mb;
    ea = exp_ea(f, b, im, of, sz, mb);
    ev = '0;
    for (int e = 0; e < ec; e++) begin
      logic [63:0] v;
      if (!pr[e]) continue;
      v = '0;
      for (int k = 0; k < mb; k++) v[k*8 +: 8] = smem[8'(ea + AW'(e*mb + k))];
      if (sg && v[mb*8-1]) for (int k = mb; k < 8; k++) v[k*8 +: 8] = 8'hFF;
      for (int k = 0; k < rb; k++) ev[(e*rb+k)*8 +: 8] = v[k*8 +: 8];
    end
    run_op(0, f, c, b, 0, 1, im, of, pr, '0);
    chk(r_done && !r_fault && !r_undef && r_req, "R10 load completes", VLEN'({r_done, r_fault, r_undef}), VLEN'(3'b100));
    chk(r_addr == ea, f ? "R4 load address" : "R5 load address", VLEN'(r_addr), VLEN'(ea));
    chk(int'(r_acc) == sz, "R6 access size", VLEN'(r_acc), VLEN'(sz));
    chk(vec_out == ev, "R1 R7 R8 load data", vec_out, ev);
  endtask

  task automatic store_case(input logic [3:0] c, input bit f, input logic [AW-1:0] b,
                            input logic [3:0] im, input logic [AW-1:0] of, input logic [VB-1:0] pr,
                            input logic [VLEN-1:0] vi);
    int rb, mb, ec, sz;
    bit sg;
    logic [AW-1:0] ea;
    fmt_of(c, rb, mb, sg);
    ec = VB / rb; sz = ec * mb;
    ea = exp_ea(f, b, im, of, sz, mb);
    for (int e = 0; e < ec; e++)
      if (pr[e]) for (int k = 0; k < mb; k++) smem[8'(ea + AW'(e*mb + k))] = vi[(e*rb+k)*8 +: 8];
    run_op(1, f, c, b, 0, 0, im, of, pr, vi);
    chk(r_done && r_req, "R10 store completes", VLEN'({r_done, r_req}), VLEN'(2'b11));
    chk(r_addr == ea, f ? "R4 store address" : "R5 store address", VLEN'(r_addr), VLEN'(ea));
    chk(mem_same(), "R9 store memory image", VLEN'(0), VLEN'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [VB-1:0] pats [3];
    logic [3:0] legal [10];
    logic [3:0] signed_codes [6];
    logic [VLEN-1:0] first_ld;
    int ndone;
    bit extra_req;
    pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h0000;
    legal = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB, 4'hF};
    signed_codes = '{4'h4, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE};
    for (int a = 0; a < 256; a++) begin
      bmem[a] = 8'(a * 37 + 11);
      smem[a] = bmem[a];
    end
    rst_n = 0; start = 0; is_store = 0; imm_form = 0; dtype = 0; base = 0;
    base_is_sp = 0; align_chk_en = 0; imm = 0; offset = 0; pred = 0; vec_in = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !fault && !undef && !mem_req, "R11 reset outputs",
        VLEN'({busy, done, fault, undef, mem_req}), VLEN'(0));
    chk(vec_out == '0, "R11 reset vec_out", vec_out, '0);
    rst_n = 1;
    @(negedge clk);

    // loads over every code, both forms, several predicates
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 3; p++)
          load_case(4'(c), f[0], AW'(32'h20 + c*7 + p), 4'(p - 1), AW'(c*3 + p), pats[p]);

    // R8 check that a previous load result is replaced by zeros
    load_case(4'h3, 0, 32'h10, 4'h0, 32'h0, 16'h0000);

    // legal stores
    for (int i = 0; i < 10; i++)
      for (int f = 0; f < 2; f++)
        store_case(legal[i], f[0], AW'(32'h90 + i*5), f ? 4'hF : 4'h1, AW'(i + 2),
                   f ? 16'h5A3C : 16'hFFFF,
                   {32'hDEADBEEF ^ 32'(i), 32'h80F1_7E02, 32'h1234_5678 + 32'(f), 32'hC0DE_FACE});
    // R10 store leaves vec_out unchanged
    first_ld = vec_out;
    store_case(4'h0, 0, 32'hE0, 4'h0, 32'h0, 16'hFFFF, {4{32'hA1B2C3D4}});
    chk(vec_out == first_ld, "R10 store keeps vec_out", vec_out, first_ld);

    // R2 illegal store codes
    for (int i = 0; i < 6; i++) begin
      run_op(1, 0, signed_codes[i], 32'h40, 0, 0, 4'h0, 32'h0, 16'hFFFF, {4{32'hFFFFFFFF}});
      chk(r_undef && !r_fault && !r_done && !r_req, "R2 signed store undef",
          VLEN'({r_undef, r_fault, r_done, r_req}), VLEN'(4'b1000));
      chk(mem_same(), "R2 memory untouched", VLEN'(0), VLEN'(1));
    end

    // R3 alignment
    run_op(0, 0, 4'h0, 32'h84, 1, 1, 4'h0, 32'h0, 16'hFFFF, '0);
    chk(r_fault && !r_done && !r_req, "R3 misaligned sp faults", VLEN'({r_fault, r_done, r_req}), VLEN'(3'b100));
    run_op(1, 0, 4'h0, 32'h8F, 1, 1, 4'h0, 32'h0, 16'hFFFF, {4{32'h55555555}});
    chk(r_fault && !r_req && mem_same(), "R3 misaligned sp store faults", VLEN'({r_fault, r_req}), VLEN'(2'b10));
    load_case(4'h5, 0, 32'h84, 4'h0, 32'h1, 16'hFFFF);  // not sp: no check
    run_op(0, 0, 4'h0, 32'h84, 1, 0, 4'h0, 32'h0, 16'hFFFF, '0);
    chk(r_done && !r_fault, "R3 check disabled", VLEN'({r_done, r_fault}), VLEN'(2'b10));
    run_op(0, 0, 4'h0, 32'h80, 1, 1, 4'h0, 32'h0, 16'hFFFF, '0);
    chk(r_done && !r_fault, "R3 aligned sp passes", VLEN'({r_done, r_fault}), VLEN'(2'b10));
    // R3 precedence: illegal store on misaligned sp
    run_op(1, 0, 4'hD, 32'h83, 1, 1, 4'h0, 32'h0, 16'hFFFF, {4{32'h77777777}});
    chk(r_undef && !r_fault && !r_req && mem_same(), "R3 undef wins over fault",
        VLEN'({r_undef, r_fault, r_req}), VLEN'(3'b100));

    // R10 start while busy is ignored
    load_case(4'h0, 0, 32'h30, 4'h0, 32'h0, 16'hFFFF);
    first_ld = vec_out;
    @(negedge clk);
    start = 1; is_store = 0; dtype = 4'h0; base = 32'h30; imm_form = 0; offset = 0;
    base_is_sp = 0; pred = 16'hFFFF;
    @(negedge clk);
    is_store = 1; dtype = 4'h0; base = 32'h30; vec_in = {4{32'h99999999}};
    @(negedge clk);
    start = 0;
    ndone = 0; extra_req = 0;
    for (int n = 0; n < 8; n++) begin
      if (done) ndone++;
      if (mem_req) extra_req = 1;
      @(negedge clk);
    end
    chk(ndone == 1 && !extra_req, "R10 start while busy ignored", VLEN'({ndone, extra_req}), VLEN'({32'd1, 1'b0}));
    chk(vec_out == first_ld && mem_same(), "R10 busy start no effect", vec_out, first_ld);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule